// File: doc/BRIEF.md
# Command Response Receiver with Word Read-Out

This block sits in an SD/MMC host controller behind the command transmitter. Once a command has gone out on the command line, the host pulses `start_i` with a two-bit response format code. The receiver then watches the command line on each card-clock sample strobe and waits for the response start bit. It shifts in a 48-bit or a 136-bit frame and checks the frame's 7-bit CRC when the format calls for one.

When the frame is complete, it is repacked into a small read queue of 16-bit words, most significant part first. Software pops the words one per read. Completion, CRC mismatch and a missing response are reported as sticky status bits at fixed positions, and completion is also mirrored into an interrupt flag vector.

The card clock appears only as a one-cycle sample strobe `sample_i` in the system clock domain. The command line is looked at only in cycles where that strobe is high.

Top module: `resp_capture`

## Requirements
- R1: Format code 0 expects no response: `status_o` bit 11 is set one cycle after `start_i` and no word becomes readable. Code 1 is a 48-bit frame with CRC check, code 2 a 136-bit frame with CRC check, and code 3 a 48-bit frame without CRC check.
- R2: `cmd_i` is sampled only in cycles with `sample_i` high. The first sampled 0 after `start_i` is the start bit and the first bit of the frame, and the frame is received most significant bit first.
- R3: If 64 consecutive samples after `start_i` are all 1, `status_o` bit 1 (timeout) and bit 11 are set and no word becomes readable. A start bit arriving on the 64th sample is still accepted.
- R4: A 48-bit frame f[47:0] is read as three words in this order: f[47:32], then f[31:16], then {8'h00, f[15:8]}.
- R5: A 136-bit frame f[135:0] is read as nine words of decreasing significance: f[135:120] down to f[23:8], then a final word {f[7:0], 8'h00}.
- R6: The CRC uses polynomial x^7+x^3+1 with a zero initial value. For code 1 it covers f[47:8] and for code 2 it covers f[127:8]; in both cases it is compared with f[7:1]. A mismatch sets `status_o` bit 5. Code 3 never sets bit 5.
- R7: `status_o` carries completion in bit 11, CRC error in bit 5 and timeout in bit 1, with all other bits 0. All three bits are cleared by `start_i`. `irq_o` bit 2 equals `status_o` bit 11, and the other `irq_o` bits are 0.
- R8: `rd_data_o` shows the oldest unread word and `rd_i` removes it. When no word is unread, `rd_data_o` is 0 and `rd_i` has no effect.
- R9: `start_i` discards every unread word, so `rd_data_o` reads 0 from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Command sent; arm the receiver for a new response |
| fmt_i | input | 2 | Response format code, taken when `start_i` is high |
| sample_i | input | 1 | Card clock sample strobe |
| cmd_i | input | 1 | Command line level |
| rd_i | input | 1 | Pop one response word |
| rd_data_o | output | 16 | Oldest unread response word, 0 when none |
| status_o | output | 16 | Status: bit 11 done, bit 5 CRC error, bit 1 timeout |
| irq_o | output | 8 | Interrupt flags: bit 2 response done |

## Verification
A lost or extra sample in the bit counter shifts every word by one bit position. It can also leave the receiver waiting forever, so completion never rises. Both show on the first response read back, a few strobes after the frame ends. A CRC register that starts or stops at the wrong bit index shows as a false or missing CRC error bit on a correctly built frame in the same cycle completion rises. Wrong read pointer or flush handling shows as a stale or non-zero word on reads past the end of a response, or on reads just after a new command starts.

// File: rtl/resp_cap_pkg.sv
package resp_cap_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_RECV,
    ST_DONE
  } cap_state_e;

  typedef enum logic [1:0] {
    FMT_NONE        = 2'd0,
    FMT_SHORT       = 2'd1,
    FMT_LONG        = 2'd2,
    FMT_SHORT_NOCRC = 2'd3
  } resp_fmt_e;

  localparam int unsigned CRC_W = 7;
  localparam logic [CRC_W-1:0] CRC_POLY = 7'h09;

  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c, input logic b);
    logic fb;
    fb = b ^ c[CRC_W-1];
    return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction

endpackage

// File: rtl/resp_crc7.sv
module resp_crc7
  import resp_cap_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             bit_i,
  output logic [CRC_W-1:0] crc_o
);

  logic [CRC_W-1:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= '0;
    else if (clr_i)  crc_q <= '0;
    else if (en_i)   crc_q <= crc_step(crc_q, bit_i);
  end

  assign crc_o = crc_q;

  AST_CRC_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> crc_q == '0); // R6

endmodule

// File: rtl/resp_rx_ctrl.sv
module resp_rx_ctrl
  import resp_cap_pkg::*;
#(
  parameter int unsigned FRAME_W       = 136,
  parameter int unsigned SHORT_BITS    = 48,
  parameter int unsigned TIMEOUT_TICKS = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [1:0]         fmt_i,
  input  logic               sample_i,
  input  logic               cmd_i,
  input  logic [CRC_W-1:0]   crc_i,
  output logic               crc_clr_o,
  output logic               crc_en_o,
  output logic               load_o,
  output logic               long_o,
  output logic [FRAME_W-1:0] frame_o,
  output logic               end_o,
  output logic               crc_err_o,
  output logic               timeout_o
);

  localparam int unsigned CNT_W       = $clog2(FRAME_W + 1);
  localparam int unsigned TO_W        = $clog2(TIMEOUT_TICKS + 1);
  localparam int unsigned TRAIL_W     = CRC_W + 1;
  localparam int unsigned SHORT_CRC_HI = SHORT_BITS - TRAIL_W;
  localparam int unsigned LONG_CRC_LO = 8;
  localparam int unsigned LONG_CRC_HI = FRAME_W - TRAIL_W;

  cap_state_e         state_q;
  resp_fmt_e          fmt_q;
  logic [CNT_W-1:0]   bit_cnt_q;
  logic [TO_W-1:0]    wait_cnt_q;
  logic [FRAME_W-1:0] shreg_q;
  logic               end_q, crc_err_q, to_q;

  logic               is_long, start_seen, recv_tick, in_crc, crc_checked;
  logic [CNT_W-1:0]   frame_len, bit_idx;

  assign is_long     = (fmt_q == FMT_LONG);
  assign frame_len   = is_long ? CNT_W'(FRAME_W) : CNT_W'(SHORT_BITS);
  assign start_seen  = sample_i && (state_q == ST_WAIT) && !cmd_i;
  assign recv_tick   = sample_i && (state_q == ST_RECV);
  assign bit_idx     = start_seen ? '0 : bit_cnt_q;
  assign in_crc      = is_long ? (bit_idx >= CNT_W'(LONG_CRC_LO) && bit_idx < CNT_W'(LONG_CRC_HI))
                               : (bit_idx < CNT_W'(SHORT_CRC_HI));
  assign crc_checked = (fmt_q == FMT_SHORT) || (fmt_q == FMT_LONG);

  assign crc_clr_o = start_i;
  assign crc_en_o  = !start_i && (start_seen || recv_tick) && in_crc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      fmt_q      <= FMT_NONE;
      bit_cnt_q  <= '0;
      wait_cnt_q <= '0;
      shreg_q    <= '0;
      end_q      <= 1'b0;
      crc_err_q  <= 1'b0;
      to_q       <= 1'b0;
    end else if (start_i) begin
      state_q    <= (resp_fmt_e'(fmt_i) == FMT_NONE) ? ST_DONE : ST_WAIT;
      fmt_q      <= resp_fmt_e'(fmt_i);
      bit_cnt_q  <= '0;
      wait_cnt_q <= '0;
      shreg_q    <= '0;
      end_q      <= 1'b0;
      crc_err_q  <= 1'b0;
      to_q       <= 1'b0;
    end else begin
      unique case (state_q)
        ST_WAIT: if (sample_i) begin
          if (!cmd_i) begin
            shreg_q   <= {shreg_q[FRAME_W-2:0], 1'b0};
            bit_cnt_q <= CNT_W'(1);
            state_q   <= ST_RECV;
          end else if (wait_cnt_q == TO_W'(TIMEOUT_TICKS - 1)) begin
            to_q    <= 1'b1;
            end_q   <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            wait_cnt_q <= wait_cnt_q + 1'b1;
          end
        end
        ST_RECV: if (sample_i) begin
          shreg_q   <= {shreg_q[FRAME_W-2:0], cmd_i};
          bit_cnt_q <= bit_cnt_q + 1'b1;
          if (bit_cnt_q == frame_len - 1'b1) state_q <= ST_DONE;
        end
        ST_DONE: begin
          end_q   <= 1'b1;
          if (crc_checked && (crc_i != shreg_q[CRC_W:1])) crc_err_q <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: ;
      endcase
    end
  end

  assign load_o    = (state_q == ST_DONE) && !start_i && (fmt_q != FMT_NONE);
  assign long_o    = is_long;
  assign frame_o   = shreg_q;
  assign end_o     = end_q;
  assign crc_err_o = crc_err_q;
  assign timeout_o = to_q;

  AST_START_CLEARS_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !end_q); // R7
  AST_WAIT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_WAIT |-> wait_cnt_q < TO_W'(TIMEOUT_TICKS)); // R3
  AST_NOCRC_FMT3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fmt_q == FMT_SHORT_NOCRC |-> !crc_err_q); // R6
  AST_TO_NO_CRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(to_q && crc_err_q)); // R3
  AST_END_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DONE && !start_i) |=> end_q); // R1

endmodule

// File: rtl/resp_word_fifo.sv
module resp_word_fifo #(
  parameter int unsigned FRAME_W    = 136,
  parameter int unsigned SHORT_BITS = 48,
  parameter int unsigned WORD_W     = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               flush_i,
  input  logic               load_i,
  input  logic               long_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic               rd_i,
  output logic [WORD_W-1:0]  rd_data_o
);

  localparam int unsigned DEPTH       = (FRAME_W + WORD_W - 1) / WORD_W;
  localparam int unsigned PAD_W       = DEPTH * WORD_W - FRAME_W;
  localparam int unsigned SHORT_WORDS = SHORT_BITS / WORD_W;
  localparam int unsigned HALF        = WORD_W / 2;
  localparam int unsigned PTR_W       = $clog2(DEPTH + 1);

  logic [DEPTH*WORD_W-1:0] padded;
  logic [WORD_W-1:0]       long_w  [DEPTH];
  logic [WORD_W-1:0]       short_w [DEPTH];
  logic [WORD_W-1:0]       mem_q   [DEPTH];
  logic [PTR_W-1:0]        cnt_q, rptr_q;
  logic                    empty;

  assign padded = {frame_i, {PAD_W{1'b0}}};

  for (genvar k = 0; k < DEPTH; k++) begin : g_word
    assign long_w[k] = padded[DEPTH*WORD_W-1-k*WORD_W -: WORD_W];
    if (k < SHORT_WORDS - 1) begin : g_full
      assign short_w[k] = frame_i[SHORT_BITS-1-k*WORD_W -: WORD_W];
    end else if (k == SHORT_WORDS - 1) begin : g_tail
      assign short_w[k] = {{HALF{1'b0}}, frame_i[WORD_W-1:HALF]};
    end else begin : g_none
      assign short_w[k] = '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                mem_q[k] <= '0;
      else if (load_i && !flush_i) mem_q[k] <= long_i ? long_w[k] : short_w[k];
    end
  end

  assign empty = (rptr_q == cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      rptr_q <= '0;
    end else if (flush_i) begin
      cnt_q  <= '0;
      rptr_q <= '0;
    end else if (load_i) begin
      cnt_q  <= long_i ? PTR_W'(DEPTH) : PTR_W'(SHORT_WORDS);
      rptr_q <= '0;
    end else if (rd_i && !empty) begin
      rptr_q <= rptr_q + 1'b1;
    end
  end

  assign rd_data_o = empty ? '0 : mem_q[rptr_q[$clog2(DEPTH)-1:0]];

  AST_PTR_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rptr_q <= cnt_q); // R8
  AST_EMPTY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && empty && !load_i && !flush_i) |=> $stable(rptr_q)); // R8
  AST_FLUSH_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> cnt_q == '0); // R9

endmodule

// File: rtl/resp_capture.sv
module resp_capture
  import resp_cap_pkg::*;
#(
  parameter int unsigned FRAME_W       = 136,
  parameter int unsigned SHORT_BITS    = 48,
  parameter int unsigned WORD_W        = 16,
  parameter int unsigned TIMEOUT_TICKS = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        fmt_i,
  input  logic              sample_i,
  input  logic              cmd_i,
  input  logic              rd_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic [15:0]       status_o,
  output logic [7:0]        irq_o
);

  localparam int unsigned ST_DONE_BIT = 11;
  localparam int unsigned ST_CRC_BIT  = 5;
  localparam int unsigned ST_TO_BIT   = 1;
  localparam int unsigned IRQ_END_BIT = 2;

  logic [CRC_W-1:0]   crc;
  logic               crc_clr, crc_en, load, is_long, resp_end, crc_err, resp_to;
  logic [FRAME_W-1:0] frame;

  resp_rx_ctrl #(
    .FRAME_W      (FRAME_W),
    .SHORT_BITS   (SHORT_BITS),
    .TIMEOUT_TICKS(TIMEOUT_TICKS)
  ) i_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .fmt_i    (fmt_i),
    .sample_i (sample_i),
    .cmd_i    (cmd_i),
    .crc_i    (crc),
    .crc_clr_o(crc_clr),
    .crc_en_o (crc_en),
    .load_o   (load),
    .long_o   (is_long),
    .frame_o  (frame),
    .end_o    (resp_end),
    .crc_err_o(crc_err),
    .timeout_o(resp_to)
  );

  resp_crc7 i_crc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (crc_clr),
    .en_i  (crc_en),
    .bit_i (cmd_i),
    .crc_o (crc)
  );

  resp_word_fifo #(
    .FRAME_W   (FRAME_W),
    .SHORT_BITS(SHORT_BITS),
    .WORD_W    (WORD_W)
  ) i_fifo (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .flush_i  (start_i),
    .load_i   (load),
    .long_i   (is_long),
    .frame_i  (frame),
    .rd_i     (rd_i),
    .rd_data_o(rd_data_o)
  );

  always_comb begin
    status_o              = '0;
    status_o[ST_DONE_BIT] = resp_end;
    status_o[ST_CRC_BIT]  = crc_err;
    status_o[ST_TO_BIT]   = resp_to;
    irq_o                 = '0;
    irq_o[IRQ_END_BIT]    = resp_end;
  end

  AST_TO_MEANS_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_to |-> rd_data_o == '0); // R3

endmodule

// File: tb/test_resp_capture.sv
module test_resp_capture;

  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  fmt_i = 2'd0;
  logic        sample_i = 1'b0;
  logic        cmd_i = 1'b1;
  logic        rd_i = 1'b0;
  logic [15:0] rd_data_o;
  logic [15:0] status_o;
  logic [7:0]  irq_o;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  logic [15:0] exp_q[$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  resp_capture i_resp_capture (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .fmt_i(fmt_i),
    .sample_i(sample_i), .cmd_i(cmd_i), .rd_i(rd_i),
    .rd_data_o(rd_data_o), .status_o(status_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] ref_crc(input logic [135:0] v, input int hi, input int lo);
    logic [6:0] c = '0;
    logic fb;
    for (int i = hi; i >= lo; i--) begin
      fb = v[i] ^ c[6];
      c = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    return c;
  endfunction

  task automatic tick(input logic b);
    @(negedge clk_i); cmd_i = b; sample_i = 1'b1;
    @(negedge clk_i); sample_i = 1'b0; cmd_i = ~b; // R2: off-strobe level must be ignored
    repeat (2) @(negedge clk_i);
  endtask

  task automatic issue(input logic [1:0] f);
    @(negedge clk_i); start_i = 1'b1; fmt_i = f;
    @(negedge clk_i); start_i = 1'b0;
  endtask

  task automatic send(input logic [135:0] frm, input int len, input int pre);
    for (int i = 0; i < pre; i++) tick(1'b1);
    for (int i = len - 1; i >= 0; i--) tick(frm[i]);
    repeat (3) @(negedge clk_i);
  endtask

  // driver side: expected words per R4/R5
  task automatic push_short(input logic [135:0] f);
    exp_q.push_back(f[47:32]);
    exp_q.push_back(f[31:16]);
    exp_q.push_back({8'h00, f[15:8]});
  endtask

  task automatic push_long(input logic [135:0] f);
    logic [143:0] p;
    p = {f, 8'h00};
    for (int k = 0; k < 9; k++) exp_q.push_back(p[143-16*k -: 16]);
  endtask

  // monitor side: pop each expected word and compare at the read port
  task automatic drain(input string req);
    logic [15:0] e;
    while (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      chk(req, rd_data_o, e);
      @(negedge clk_i); rd_i = 1'b1;
      @(negedge clk_i); rd_i = 1'b0;
    end
  endtask

  function automatic logic [135:0] mk_short(input logic [5:0] idx, input logic [31:0] arg, input bit bad);
    logic [135:0] f = '0;
    f[47:8] = {2'b00, idx, arg};
    f[7:1] = ref_crc(f, 47, 8) ^ (bad ? 7'h01 : 7'h00);
    f[0] = 1'b1;
    return f;
  endfunction

  function automatic logic [135:0] mk_long(input logic [119:0] body, input bit bad);
    logic [135:0] f;
    f = {8'h3F, body, 8'h00};
    f[7:1] = ref_crc(f, 127, 8) ^ (bad ? 7'h40 : 7'h00);
    f[0] = 1'b1;
    return f;
  endfunction

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      summary();
    end
  end

  initial begin
    logic [135:0] f;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R7 reset status", status_o, 16'h0000);
    chk("R8 reset read", rd_data_o, 16'h0000);

    // R4 R6 short frame, good CRC, idle before start bit
    f = mk_short(6'h11, 32'hA5C3_0F96, 0);
    issue(2'd1); send(f, 48, 5); push_short(f);
    chk("R6 short good crc status", status_o, 16'h0800);
    chk("R7 irq mirrors done", irq_o, 8'h04);
    drain("R4 short words");
    chk("R8 empty read zero", rd_data_o, 16'h0000);
    @(negedge clk_i); rd_i = 1'b1; @(negedge clk_i); rd_i = 1'b0;
    chk("R8 pop on empty no effect", rd_data_o, 16'h0000);

    // R6 short bad CRC
    f = mk_short(6'h2A, 32'h1234_5678, 1);
    issue(2'd1); send(f, 48, 0); push_short(f);
    chk("R6 short bad crc status", status_o, 16'h0820);
    drain("R4 short words bad crc");

    // R1 R6 format 3 ignores CRC
    f = mk_short(6'h3F, 32'hFFFF_0000, 1);
    issue(2'd3); send(f, 48, 2); push_short(f);
    chk("R6 fmt3 no crc check", status_o, 16'h0800);
    drain("R1 fmt3 words");

    // R5 long frame good CRC
    f = mk_long(120'h0123_4567_89AB_CDEF_FEDC_BA98_7654_32, 0);
    issue(2'd2); send(f, 136, 3); push_long(f);
    chk("R6 long good crc status", status_o, 16'h0800);
    drain("R5 long words");
    chk("R8 long empty after nine", rd_data_o, 16'h0000);

    // R6 long bad CRC
    f = mk_long(120'hDEAD_BEEF_0000_1111_2222_3333_4444_55, 1);
    issue(2'd2); send(f, 136, 0); push_long(f);
    chk("R6 long bad crc status", status_o, 16'h0820);
    drain("R5 long words bad crc");

    // R3 timeout after 64 idle samples
    issue(2'd1); send(136'h0, 0, 64);
    chk("R3 timeout status", status_o, 16'h0802);
    chk("R3 timeout no words", rd_data_o, 16'h0000);

    // R3 R2 start bit on 64th sample accepted
    f = mk_short(6'h05, 32'hCAFE_F00D, 0);
    issue(2'd1); send(f, 48, 63); push_short(f);
    chk("R3 late start accepted", status_o, 16'h0800);
    drain("R2 late start words");

    // R1 no response format
    issue(2'd0);
    @(negedge clk_i);
    chk("R1 fmt0 done", status_o, 16'h0800);
    chk("R1 fmt0 no words", rd_data_o, 16'h0000);

    // R9 flush unread words, R7 status cleared
    f = mk_short(6'h01, 32'h8765_4321, 0);
    issue(2'd1); send(f, 48, 1);
    chk("R4 first word before flush", rd_data_o, f[47:32]);
    @(negedge clk_i); rd_i = 1'b1; @(negedge clk_i); rd_i = 1'b0;
    issue(2'd1);
    chk("R9 flush on start", rd_data_o, 16'h0000);
    chk("R7 status cleared on start", status_o, 16'h0000);

    finished = 1;
    summary();
  end

endmodule